// File: doc/BRIEF.md
# Clock Output Bank Controller

This block is one output bank of a multi-PLL clock generator. A select field picks one of four candidate clocks: three PLL outputs and the reference clock that is currently chosen upstream. The chosen clock goes through a post-divider with a 10-bit programmed value. A mode bit sets the divider to divide either by the programmed value plus two or by a fixed two. The result then passes through an output gate that holds the level low when the output is disabled or when the chip-wide shutdown is active. A final invert bit is applied after the gate.

The block is written as synchronous logic running on a fast system clock `clk`. The candidate clocks are sampled as levels. A rising edge of the selected candidate advances the divider. The registered output `clk_o` is the bank clock. A parameter builds the bank-one variant, which has no post-divider: it passes the selected clock straight to the gate. Changes to the divider value are held back until the divider wraps, so a reprogrammed divider never emits a shortened pulse. Turning the divider power bit on restarts the divider cleanly on the next source rising edge.

Top module: `ocb_bank`

## Requirements
- R1: `sel_i` picks the source: code 0, 1 and 2 select PLL outputs `src_i[0]`, `src_i[1]` and `src_i[2]`, and code 3 selects the reference clock `src_i[3]`.
- R2: While `rst` is high at a clock edge, `clk_o` becomes 0 and the divider stops.
- R3: With `div_mode_i`=1 and the divider powered, the output period is N=`div_val_i`+2 source rising edges. The output is high for the first ceil(N/2) of those edges, counted from the restart or the wrap.
- R4: With `div_mode_i`=0, the divider divides by exactly 2 whatever `div_val_i` holds.
- R5: A new value or mode is loaded only when the count wraps, after N edges of the old ratio. The phase in progress is never cut short.
- R6: With `div_pwr_i`=0, the divided level is held low and the count is cleared. After power returns, the first selected rising edge restarts the count at zero, in the high phase.
- R7: `invert_i`=1 inverts `clk_o`. The inversion is applied after gating.
- R8: With `oe_i`=0, `clk_o` stays static at the level of `invert_i`.
- R9: With `shutdown_i`=1, `clk_o` stays static at the level of `invert_i`, whatever `oe_i` holds.
- R10: When `HAS_DIV`=0, `clk_o` follows the selected source with no division. In that variant `div_val_i`, `div_mode_i` and `div_pwr_i` have no effect.
- R11: A rising edge is detected in the cycle where the sampled selected level is 1 and was 0 in the previous cycle. The divider advances at that clock edge, and `clk_o` reflects the new state one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all candidate clocks |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC (4) | Candidate clock levels: three PLL outputs, then the reference |
| sel_i | input | SEL_W (2) | Source select code |
| div_val_i | input | DIV_W (10) | Programmed post-divider value |
| div_mode_i | input | 1 | 1: divide by value plus two; 0: divide by two |
| div_pwr_i | input | 1 | Divider power; 0 stops the divider |
| invert_i | input | 1 | Output inversion |
| oe_i | input | 1 | Per-output enable |
| shutdown_i | input | 1 | Chip-wide shutdown |
| clk_o | output | 1 | Bank output clock |

## Verification
The assertions assume that the candidate clocks are slow, level-sampled signals: each high and low phase lasts at least one system clock. They also assume that a rising edge is an event seen in a single sample. A source change, or a selection change that creates an edge, is treated as legitimate, so no property forbids one. The stimulus keeps within these limits. It generates the four candidates as square waves with half periods of 2 to 5 system clocks, changes configuration only at falling edges of `clk`, and switches the select code and the divider value at arbitrary points in the divider cycle. This exercises reloads that must wait for a wrap.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

    localparam int OCB_NSRC  = 4;
    localparam int OCB_DIV_W = 10;

    typedef enum logic [1:0] {
        SRC_PLL_A = 2'd0,
        SRC_PLL_B = 2'd1,
        SRC_PLL_C = 2'd2,
        SRC_REF   = 2'd3
    } ocb_src_e;

    typedef enum logic {
        DIV_FIXED2 = 1'b0,
        DIV_PLUS2  = 1'b1
    } ocb_div_mode_e;

    typedef struct packed {
        logic invert;
        logic enable;
        logic halt;
    } ocb_gate_t;

    // Division ratio selected by the mode bit.
    function automatic int unsigned ratio_of(int unsigned val, ocb_div_mode_e mode);
        return (mode == DIV_PLUS2) ? val + 32'd2 : 32'd2;
    endfunction

    // Number of source edges spent in the high phase.
    function automatic int unsigned high_len(int unsigned n);
        return (n + 32'd1) / 32'd2;
    endfunction

endpackage

// File: rtl/ocb_src_mux.sv
module ocb_src_mux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             rise_o,
    output logic             dly_o
);

    logic pick;
    logic dly_q;

    always_comb begin
        pick = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (int'(sel_i) == k) begin
                pick = src_i[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= 1'b0;
        end else begin
            dly_q <= pick;
        end
    end

    assign rise_o = pick & ~dly_q;
    assign dly_o  = dly_q;

endmodule

// File: rtl/ocb_post_div.sv
module ocb_post_div
    import ocb_pkg::*;
#(
    parameter int DIV_W = OCB_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             pwr_i,
    input  logic [DIV_W-1:0] val_i,
    input  ocb_div_mode_e    mode_i,
    output logic             lvl_o
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] n_cfg;
    logic [CNT_W-1:0] n_last;
    logic [CNT_W-1:0] n_high;
    logic             run_q;

    assign n_cfg  = CNT_W'(ratio_of(int'(val_i), mode_i));
    assign n_last = n_q - CNT_W'(1);
    assign n_high = CNT_W'(high_len(int'(n_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            n_q   <= CNT_W'(2);
        end else if (!pwr_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (rise_i) begin
            if (!run_q) begin
                run_q <= 1'b1;
                cnt_q <= '0;
                n_q   <= n_cfg;
            end else if (cnt_q == n_last) begin
                cnt_q <= '0;
                n_q   <= n_cfg;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign lvl_o = run_q && (cnt_q < n_high);

endmodule

// File: rtl/ocb_out_gate.sv
module ocb_out_gate
    import ocb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    input  ocb_gate_t ctl_i,
    output logic      out_o
);

    logic pass;
    logic out_q;

    assign pass = lvl_i & ctl_i.enable & ~ctl_i.halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            out_q <= pass ^ ctl_i.invert;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/ocb_bank.sv
module ocb_bank
    import ocb_pkg::*;
#(
    parameter int NSRC    = OCB_NSRC,
    parameter int DIV_W   = OCB_DIV_W,
    parameter int SEL_W   = $clog2(NSRC),
    parameter bit HAS_DIV = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [DIV_W-1:0] div_val_i,
    input  logic             div_mode_i,
    input  logic             div_pwr_i,
    input  logic             invert_i,
    input  logic             oe_i,
    input  logic             shutdown_i,
    output logic             clk_o
);

    logic      src_rise;
    logic      src_dly;
    logic      pd_lvl;
    logic      div_lvl;
    ocb_gate_t gate_ctl;

    ocb_src_mux #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W)
    ) u_mux (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .sel_i  (sel_i),
        .rise_o (src_rise),
        .dly_o  (src_dly)
    );

    generate
        if (HAS_DIV) begin : g_div
            ocb_post_div #(
                .DIV_W (DIV_W)
            ) u_div (
                .clk    (clk),
                .rst    (rst),
                .rise_i (src_rise),
                .pwr_i  (div_pwr_i),
                .val_i  (div_val_i),
                .mode_i (ocb_div_mode_e'(div_mode_i)),
                .lvl_o  (pd_lvl)
            );
        end else begin : g_nodiv
            assign pd_lvl = 1'b0;
        end
    endgenerate

    assign div_lvl = HAS_DIV ? pd_lvl : src_dly;

    always_comb begin
        gate_ctl.invert = invert_i;
        gate_ctl.enable = oe_i;
        gate_ctl.halt   = shutdown_i;
    end

    ocb_out_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (div_lvl),
        .ctl_i (gate_ctl),
        .out_o (clk_o)
    );

endmodule

// File: rtl/ocb_bank_chk.sv
module ocb_div_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             rise_i,
    input logic             pwr_i,
    input logic             lvl_o,
    input logic             run_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] n_q
);

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < n_q));

    p_hold_between_edges_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_i && !rise_i) |=> ($stable(cnt_q) && $stable(n_q)));

    p_ratio_floor_r4: assert property (@(posedge clk) disable iff (rst)
        n_q >= CNT_W'(2));

    p_load_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(n_q) |-> (cnt_q == '0));

    p_power_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !pwr_i |=> (!lvl_o && !run_q));

endmodule

module ocb_bank_chk (
    input logic clk,
    input logic rst,
    input logic oe_i,
    input logic shutdown_i,
    input logic invert_i,
    input logic clk_o
);

    p_disabled_static_r8: assert property (@(posedge clk) disable iff (rst)
        (!oe_i && !shutdown_i) |=> (clk_o == $past(invert_i)));

    p_shutdown_static_r9: assert property (@(posedge clk) disable iff (rst)
        shutdown_i |=> (clk_o == $past(invert_i)));

endmodule

bind ocb_post_div ocb_div_chk #(.CNT_W(CNT_W)) u_div_chk (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise_i),
    .pwr_i  (pwr_i),
    .lvl_o  (lvl_o),
    .run_q  (run_q),
    .cnt_q  (cnt_q),
    .n_q    (n_q)
);

bind ocb_bank ocb_bank_chk u_bank_chk (
    .clk        (clk),
    .rst        (rst),
    .oe_i       (oe_i),
    .shutdown_i (shutdown_i),
    .invert_i   (invert_i),
    .clk_o      (clk_o)
);

// File: tb/ocb_bank_bench.sv
`timescale 1ns/1ps
module ocb_bank_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src = 4'b0;
    logic [1:0] sel = 2'd3;
    logic [9:0] val = 10'd0;
    logic       mode = 1'b1;
    logic       pwr = 1'b1;
    logic       inv = 1'b0;
    logic       oe = 1'b1;
    logic       sd = 1'b0;
    logic       clk_o;
    logic       clk_first;

    always #4 clk = ~clk;

    ocb_bank u_ocb_bank (
        .clk(clk), .rst(rst), .src_i(src), .sel_i(sel), .div_val_i(val),
        .div_mode_i(mode), .div_pwr_i(pwr), .invert_i(inv), .oe_i(oe),
        .shutdown_i(sd), .clk_o(clk_o)
    );

    ocb_bank #(.HAS_DIV(1'b0)) u_ocb_bank_first (
        .clk(clk), .rst(rst), .src_i(src), .sel_i(sel), .div_val_i(val),
        .div_mode_i(mode), .div_pwr_i(pwr), .invert_i(inv), .oe_i(oe),
        .shutdown_i(sd), .clk_o(clk_first)
    );

    int    vecs = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string req = "R2";
    int    hp [4] = '{2, 3, 4, 5};

    // Reference state: edge history, running flag, edge count, active ratio.
    bit m_prev, m_run, m_out, b_out;
    int m_cnt, m_n;

    task automatic cmp(string r, logic act, logic exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", r, act, exp, $time);
        end
    endtask

    task automatic step();
        bit s, rise, lvl, on;
        int cfg;
        @(negedge clk);
        for (int k = 0; k < 4; k++) src[k] = ((cyc / hp[k]) % 2) == 1;
        cyc++;
        s    = src[sel];
        rise = s && !m_prev;
        if (rst) begin
            m_prev = 0; m_run = 0; m_cnt = 0; m_n = 2; m_out = 0; b_out = 0;
        end else begin
            lvl   = m_run && (m_cnt < (m_n + 1) / 2);
            on    = oe && !sd;
            m_out = (lvl && on) ^ inv;
            b_out = (m_prev && on) ^ inv;
            cfg   = mode ? int'(val) + 2 : 2;
            if (!pwr) begin
                m_run = 0; m_cnt = 0;
            end else if (rise) begin
                if (!m_run) begin
                    m_run = 1; m_cnt = 0; m_n = cfg;
                end else if (m_cnt == m_n - 1) begin
                    m_cnt = 0; m_n = cfg;
                end else begin
                    m_cnt++;
                end
            end
            m_prev = s;
        end
        @(posedge clk);
        #1;
        cmp(req, clk_o, m_out);
        cmp("R10", clk_first, b_out);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        // R2: reset holds both outputs low
        req = "R2";
        run(4);
        cmp("R2", clk_o, 1'b0);
        rst = 1'b0;
        // R1: reference source, ratio 2
        req = "R1";
        run(40);
        sel = 2'd0; run(40);
        sel = 2'd1; run(40);
        sel = 2'd2; run(40);
        // R11: select switching mid-cycle, edge timing
        req = "R11";
        sel = 2'd0; run(7);
        sel = 2'd3; run(9);
        sel = 2'd1; run(30);
        // R3: odd and even ratios
        req = "R3";
        sel = 2'd0; val = 10'd3; run(80);
        val = 10'd4; run(80);
        // R5: reprogramming mid-phase waits for the wrap
        req = "R5";
        val = 10'd9; run(23);
        val = 10'd1; run(17);
        mode = 1'b0; run(11);
        mode = 1'b1; val = 10'd6; run(70);
        // R3: maximum value keeps the high phase long
        req = "R3";
        val = 10'd1023; run(200);
        // R6: power off then restart
        req = "R6";
        pwr = 1'b0; run(20);
        cmp("R6", clk_o, inv);
        pwr = 1'b1; val = 10'd2; run(60);
        // R4: fixed divide ignores the value
        req = "R4";
        mode = 1'b0; val = 10'd9; run(60);
        val = 10'd500; run(40);
        // R7: inversion
        req = "R7";
        mode = 1'b1; val = 10'd1; inv = 1'b1; run(50);
        // R8: enable off gives static inverted level
        req = "R8";
        oe = 1'b0; run(20);
        cmp("R8", clk_o, inv);
        inv = 1'b0; run(10);
        cmp("R8", clk_o, 1'b0);
        oe = 1'b1; run(20);
        // R9: shutdown overrides enable
        req = "R9";
        sd = 1'b1; run(20);
        cmp("R9", clk_o, 1'b0);
        inv = 1'b1; oe = 1'b0; run(10);
        cmp("R9", clk_o, 1'b1);
        sd = 1'b0; oe = 1'b1; inv = 1'b0; run(20);
        // R10: divider controls toggled; the first-bank variant must not care
        req = "R10";
        pwr = 1'b0; sel = 2'd3; run(30);
        pwr = 1'b1; mode = 1'b0; val = 10'd77; run(30);
        // R2: reset again mid-run
        req = "R2";
        rst = 1'b1; run(3);
        cmp("R2", clk_o, 1'b0);
        cmp("R2", clk_first, 1'b0);
        rst = 1'b0; run(20);
        finish_up();
    end

endmodule